// File: doc/BRIEF.md
# Serial Sine-Sample DAC Feeder

This block streams a sine waveform to a serial DAC. Each start request sends one 24-bit frame. The frame carries the next entry of an internal sine table, and the table pointer moves by one entry per frame. The frame rate therefore sets the frequency of the output sine. The bit is placed on a data line most significant bit first. An active-low frame-sync line frames the transfer, and a serial clock runs during it.

The whole block runs in one clock domain. A prescaler gives a one-cycle enable every `DIV` system clocks. The serial clock is a flip-flop output that toggles on that enable. It never clocks any flip-flop. The start input may come from another domain. It passes through a two-stage synchronizer and is then treated as a level. A request that arrives while a frame is in flight is dropped. A request that is held high gives back-to-back frames.

Top module: `sine_dac_feeder`

## Requirements
- R1: After reset, sync_no is 1, sclk_o is 0, sdata_o is 0 and busy_o is 0.
- R2: A start_i pulse as short as one clock cycle is taken. If start_i is high at rising edge k and no frame is running, sync_no goes low after edge k+2.
- R3: Each sclk_o high phase and each low phase inside a frame lasts exactly DIV clock cycles, so successive rising edges are 2*DIV cycles apart. DIV is a parameter of at least 2.
- R4: Inside a frame, sdata_o changes only when sclk_o falls or when a frame loads. Each bit is therefore stable at the rising edge of sclk_o, and the first rising edge presents the MSB.
- R5: sync_no stays low for exactly 24 rising edges of sclk_o. It returns high on the same cycle as the 24th falling edge. The low time is 47*DIV+d cycles, where d is between 1 and DIV and depends on the prescaler phase at load.
- R6: busy_o is high exactly while sync_no is low. Start requests that arrive during a frame are ignored and cause no later frame.
- R7: Frames carry the entries in order: frame k sends entry k mod DEPTH. Entry i is the offset-binary value 2^23 + floor((2^23-1)*sin(2*pi*i/DEPTH) + 0.5). DEPTH is a power of two.
- R8: After the last table entry, the pointer wraps, so frame DEPTH sends entry 0 again.
- R9: If start_i stays high, the next frame loads on the cycle after sync_no rises, so sync_no is high for exactly one cycle between frames.
- R10: Between frames, sclk_o stays low and shows no edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Asynchronous frame request |
| sclk_o | output | 1 | Serial bit clock to the DAC |
| sync_no | output | 1 | Frame sync, low during the transfer |
| sdata_o | output | 1 | Serial data, MSB first |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
Two pairs of events can fall in the same cycle. First, the frame load can coincide with a prescaler enable. The bench sweeps the idle gap before each request across every prescaler phase. It then judges the load by the low time of sync_no, which must stay inside its window, and by the fixed spacing of the serial clock edges. Second, the end of a frame can coincide with a pending request. The bench holds start_i high across a frame end and requires exactly one high cycle of sync_no before the next sample starts. Separately, the bench injects stray pulses both early in a frame and close to its end, and expects no extra frame from either.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam real PI_C = 3.141592653589793;

  typedef enum logic {PH_RISE = 1'b0, PH_FALL = 1'b1} bit_phase_e;

  // offset-binary sine code, evaluated at elaboration only
  function automatic int sine_code(int idx, int depth, int w);
    real amp;
    real v;
    amp = 2.0 ** (w - 1) - 1.0;
    v   = amp * $sin(2.0 * PI_C * real'(idx) / real'(depth));
    return $rtoi(2.0 ** (w - 1) + v + 0.5);
  endfunction

endpackage

// File: rtl/sdac_sync2.sv
module sdac_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 2'b00;
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/sdac_tick.sv
module sdac_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  initial assert (DIV >= 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))    cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CW'(DIV - 1));

  assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sdac_sine_rom.sv
module sdac_sine_rom #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [WIDTH-1:0] sample_o
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] tbl [DEPTH];
  logic [AW-1:0]    idx_q;

  initial assert ((DEPTH & (DEPTH - 1)) == 0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = WIDTH'(sdac_pkg::sine_code(g, DEPTH, WIDTH));
  end

  // power-of-two depth: natural overflow wraps the pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= idx_q + 1'b1;
  end

  assign sample_o = tbl[idx_q];

  assert_idx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] sample_i,
  output logic             take_o,
  output logic             sclk_o,
  output logic             sync_no,
  output logic             sdata_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] shreg_q;
  logic [CNT_W-1:0] bit_cnt_q;
  bit_phase_e       phase_q;
  logic             busy_q, sync_nq, sclk_q;

  assign take_o = req_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      phase_q   <= PH_RISE;
      busy_q    <= 1'b0;
      sync_nq   <= 1'b1;
      sclk_q    <= 1'b0;
    end else if (take_o) begin
      shreg_q   <= sample_i;
      bit_cnt_q <= '0;
      phase_q   <= PH_RISE;
      busy_q    <= 1'b1;
      sync_nq   <= 1'b0;
      sclk_q    <= 1'b0;
    end else if (busy_q && tick_i) begin
      if (phase_q == PH_RISE) begin
        sclk_q  <= 1'b1;
        phase_q <= PH_FALL;
      end else begin
        sclk_q  <= 1'b0;
        phase_q <= PH_RISE;
        shreg_q <= {shreg_q[WIDTH-2:0], 1'b0};
        if (bit_cnt_q == CNT_W'(WIDTH - 1)) begin
          busy_q  <= 1'b0;
          sync_nq <= 1'b1;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign sync_no = sync_nq;
  assign sdata_o = shreg_q[WIDTH-1];
  assign busy_o  = busy_q;

  assert_sclk_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_q) |-> $past(tick_i));
  assert_sdata_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> ($fell(sclk_q) || $fell(sync_nq)));
  assert_bitcnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bit_cnt_q < CNT_W'(WIDTH)));
  assert_end_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_nq) |-> $fell(sclk_q));
  assert_busy_sync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q != sync_nq);
  assert_idle_sclk_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
endmodule

// File: rtl/sine_dac_feeder.sv
module sine_dac_feeder #(
  parameter int DIV   = 4,
  parameter int DEPTH = 16,
  parameter int WIDTH = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic sclk_o,
  output logic sync_no,
  output logic sdata_o,
  output logic busy_o
);
  logic             start_s, tick, take;
  logic [WIDTH-1:0] sample;

  sdac_sync2 u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (start_i),
    .q_o   (start_s)
  );

  sdac_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sdac_sine_rom #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (take),
    .sample_o(sample)
  );

  sdac_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (start_s),
    .tick_i  (tick),
    .sample_i(sample),
    .take_o  (take),
    .sclk_o  (sclk_o),
    .sync_no (sync_no),
    .sdata_o (sdata_o),
    .busy_o  (busy_o)
  );
endmodule

// File: tb/sine_dac_feeder_test.sv
module sine_dac_feeder_test;
  localparam int DIV   = 3;
  localparam int DEPTH = 16;
  localparam int WIDTH = 24;

  logic clk = 1'b0;
  logic rst_ni, start_i;
  logic sclk_o, sync_no, sdata_o, busy_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sine_dac_feeder #(.DIV(DIV), .DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .sclk_o(sclk_o), .sync_no(sync_no), .sdata_o(sdata_o), .busy_o(busy_o)
  );

  function automatic longint exp_sample(int i);
    real amp, v;
    amp = 2.0 ** (WIDTH - 1) - 1.0;
    v   = amp * $sin(2.0 * 3.141592653589793 * real'(i) / real'(DEPTH));
    return longint'($rtoi(2.0 ** (WIDTH - 1) + v + 0.5));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet(int cycles);
    bit ok = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (!sync_no || sclk_o || busy_o) ok = 1'b0;
    end
    check(ok, "R6/R10 idle quiet", ok, 1);
  endtask

  // entered on the negedge where sync_no is first seen low
  task automatic collect_frame(int idx, int spur_at, string rq);
    longint word = 0;
    int rises = 0, low = 0, last_rise = -1;
    bit prev_sclk = sclk_o, prev_sd = sdata_o;
    bit gap_ok = 1'b1, sd_ok = 1'b1, busy_ok = 1'b1;
    while (!sync_no && low < 4000) begin
      if (!busy_o) busy_ok = 1'b0;
      if (spur_at >= 0) start_i = (low == spur_at);
      low++;
      @(negedge clk);
      if (!prev_sclk && sclk_o) begin
        if (last_rise >= 0 && low - last_rise != 2 * DIV) gap_ok = 1'b0;
        last_rise = low;
        word = (word << 1) | longint'(sdata_o);
        rises++;
      end
      if (sdata_o != prev_sd && !(prev_sclk && !sclk_o)) sd_ok = 1'b0;
      prev_sclk = sclk_o;
      prev_sd   = sdata_o;
    end
    if (spur_at >= 0) start_i = 1'b0;
    check(rises == WIDTH, "R5 rising edges per frame", rises, WIDTH);
    check(word == exp_sample(idx), rq, word, exp_sample(idx));
    check(gap_ok, "R3 sclk edge spacing", gap_ok, 1);
    check(sd_ok, "R4 sdata change timing", sd_ok, 1);
    check(busy_ok, "R6 busy during frame", busy_ok, 1);
    check(low >= 47 * DIV + 1 && low <= 48 * DIV, "R5 sync low length", low, 47 * DIV + 1);
    check(!sclk_o && !busy_o, "R5 end state", {sclk_o, busy_o}, 0);
  endtask

  task automatic run_frame(int idx, int spur_at, int pre_idle, string rq);
    repeat (pre_idle) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(sync_no, "R2 latency edge+1", sync_no, 1);
    @(negedge clk);
    check(sync_no, "R2 latency edge+2", sync_no, 1);
    @(negedge clk);
    check(!sync_no && busy_o, "R2 load after edge+3", sync_no, 0);
    collect_frame(idx, spur_at, rq);
    quiet(6 * DIV + 3);
  endtask

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(sync_no, "R1 reset sync", sync_no, 1);
    check(!sclk_o, "R1 reset sclk", sclk_o, 0);
    check(!sdata_o, "R1 reset sdata", sdata_o, 0);
    check(!busy_o, "R1 reset busy", busy_o, 0);
    rst_ni = 1'b1;
    quiet(10);

    for (int f = 0; f < DEPTH + 4; f++) begin
      int spur;
      case (f % 3)
        0:       spur = -1;
        1:       spur = 10;
        default: spur = 46 * DIV;
      endcase
      run_frame(f % DEPTH, spur, f % (2 * DIV) + 1, (f >= DEPTH) ? "R8 wrap sample" : "R7 sample");
    end

    // R9: held request spans a frame end
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    check(!sync_no, "R9 first held frame load", sync_no, 0);
    collect_frame((DEPTH + 4) % DEPTH, -1, "R9 held frame sample");
    @(negedge clk);
    check(!sync_no, "R9 one-cycle sync gap", sync_no, 0);
    start_i = 1'b0;
    collect_frame((DEPTH + 5) % DEPTH, -1, "R9 second held sample");
    quiet(8 * DIV);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule